// File: doc/BRIEF.md
# Interrupt Gate and Sleep-Mode Controller

This block collects interrupt requests from fourteen sources into a pending-flag register. It masks them with a per-source enable register and a global master switch, and it drives a single interrupt line to the processor. Sources report events as one-cycle pulses. Software acknowledges a flag by writing a one to its bit.

The same block also runs the power state of the processor complex. Software asks for one of two sleep states by writing to a mode register. From that point the block decides whether the processor may execute, whether the DMA engine may move data, and whether the timers receive tick enables.

The two sleep states differ in how they end:
- Light sleep (halt) keeps DMA and timers running. Any enabled, pending interrupt ends it, whatever the master switch holds.
- Deep sleep (stop) freezes DMA and timers. Only the keypad source ends it.

The state machine has three states: `MODE_NORMAL`, `MODE_HALT` and `MODE_STOP`. It has four transitions:
- NORMAL→HALT: a halt request is written while nothing enabled is pending.
- NORMAL→STOP: a stop request is written while no enabled keypad flag is pending.
- HALT→NORMAL: any enabled flag becomes pending.
- STOP→NORMAL: the enabled keypad flag becomes pending.

Top module: `pwr_irq_ctrl`

## Requirements
- R1: After reset the enable register, the flag register and the master switch read zero. The mode is normal, irq_line is 0, and cpu_run, dma_run and timer_tick_enable are all 1.
- R2: irq_line is 1 exactly when the master switch is set and some bit is set in both the enable register and the flag register.
- R3: A pulse on irq_src[i] sets flag bit i on the next edge. Writing 1 to a bit of the flag register (address 1) clears that bit, and writing 0 leaves it unchanged. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Writing the value 1 to the mode register (address 3) in normal mode, while the AND of enable and flag is zero, enters halt on the next edge. In halt, cpu_run is 0 while dma_run and timer_tick_enable stay 1.
- R5: In halt, the mode returns to normal on the edge after the AND of enable and flag becomes non-zero, even when the master switch is clear. Flags that are not enabled keep the block in halt.
- R6: Writing the value 2 to the mode register in normal mode, while enable bit 12 AND flag bit 12 is zero, enters stop on the next edge. In stop, cpu_run, dma_run and timer_tick_enable are all 0.
- R7: In stop, the only way back to normal is enable bit 12 (keypad) together with flag bit 12. The return happens on the edge after that condition holds, and any other enabled pending flag leaves the block in stop.
- R8: A halt or stop request written while that mode's wake condition already holds leaves the mode normal.
- R9: Register map, with reads combinational on rd_addr:
  - address 0 holds the enable register in bits 13:0.
  - address 1 holds the flag register in bits 13:0.
  - address 2 holds the master switch in bit 0.
  - address 3 reads back the mode as 0 (normal), 1 (halt) or 2 (stop).
  - Unused bits read zero.
- R10: A mode-register write with any value other than 1 or 2 is ignored, and so is any mode-register write made outside normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data |
| irq_src | input | 14 | One-cycle event pulses, one per source |
| irq_line | output | 1 | Interrupt request to the processor |
| cpu_run | output | 1 | Processor may execute |
| dma_run | output | 1 | DMA engine may run |
| timer_tick_enable | output | 1 | Timers may advance |

## Verification
The assertions watch every cycle for the following:
- the gating of the run outputs in each mode;
- the stop state holding until the keypad condition appears;
- the halt state ending one edge after any enabled flag is pending;
- source pulses always winning over a clear;
- acknowledged flags going to zero.

Some behaviour needs deliberate sequences, and only the bench scenarios show it. These include:
- a request refused because its wake condition is already true;
- a master switch that is clear during a halt wake;
- a non-keypad interrupt being ignored in stop;
- invalid mode codes;
- register readback.

A behavioural reference model compares every output on every cycle while these scenarios run.

// File: rtl/pwrirq_pkg.sv
`timescale 1ns/1ps
package pwrirq_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_HALT   = 2'd1,
        MODE_STOP   = 2'd2
    } pm_mode_e;

    localparam logic [1:0] REG_ENABLE = 2'd0;
    localparam logic [1:0] REG_FLAG   = 2'd1;
    localparam logic [1:0] REG_MASTER = 2'd2;
    localparam logic [1:0] REG_MODE   = 2'd3;
endpackage

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
    import pwrirq_pkg::*;
#(
    parameter int SRC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [SRC_W-1:0] wr_bits,
    input  logic             wr_bit0,
    input  logic [SRC_W-1:0] src_pulse,
    output logic [SRC_W-1:0] enable_q,
    output logic [SRC_W-1:0] flag_q,
    output logic             master_q
);
    logic             en_wr, flag_wr, mst_wr;
    logic [SRC_W-1:0] clr_mask;

    always_comb begin
        en_wr    = wr_en && (wr_addr == REG_ENABLE);
        flag_wr  = wr_en && (wr_addr == REG_FLAG);
        mst_wr   = wr_en && (wr_addr == REG_MASTER);
        clr_mask = flag_wr ? wr_bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            flag_q   <= '0;
            master_q <= 1'b0;
        end else begin
            if (en_wr)  enable_q <= wr_bits;
            if (mst_wr) master_q <= wr_bit0;
            flag_q <= (flag_q & ~clr_mask) | src_pulse;
        end
    end

    // R3: a source pulse always lands in the flag register
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse != '0) |=> ((flag_q & $past(src_pulse)) == $past(src_pulse)));

    // R3: acknowledged bits are cleared when no pulse arrives
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && src_pulse == '0) |=> ((flag_q & $past(wr_bits)) == '0));
endmodule

// File: rtl/pm_fsm.sv
`timescale 1ns/1ps
module pm_fsm
    import pwrirq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] mode_wdata,
    input  logic              any_pending,
    input  logic              key_pending,
    output pm_mode_e          mode_q,
    output logic              cpu_run,
    output logic              dma_run,
    output logic              timer_en
);
    localparam logic [DATA_W-1:0] REQ_HALT = DATA_W'(1);
    localparam logic [DATA_W-1:0] REQ_STOP = DATA_W'(2);

    pm_mode_e mode_d;

    // next-state decision
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL: begin
                if (mode_wr && mode_wdata == REQ_HALT && !any_pending)
                    mode_d = MODE_HALT;
                else if (mode_wr && mode_wdata == REQ_STOP && !key_pending)
                    mode_d = MODE_STOP;
            end
            MODE_HALT:   if (any_pending) mode_d = MODE_NORMAL;
            MODE_STOP:   if (key_pending) mode_d = MODE_NORMAL;
            default:     mode_d = MODE_NORMAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_d;
    end

    // outputs from state
    always_comb begin
        cpu_run  = 1'b0;
        dma_run  = 1'b0;
        timer_en = 1'b0;
        unique case (mode_q)
            MODE_NORMAL: begin cpu_run = 1'b1; dma_run = 1'b1; timer_en = 1'b1; end
            MODE_HALT:   begin dma_run = 1'b1; timer_en = 1'b1; end
            MODE_STOP:   ;
            default:     ;
        endcase
    end

    // R4: halt parks only the processor
    p_halt_gating_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HALT) |-> (!cpu_run && dma_run && timer_en));

    // R6: stop freezes every consumer
    p_stop_gating_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP) |-> (!cpu_run && !dma_run && !timer_en));

    // R5: any enabled pending flag ends halt one edge later
    p_halt_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HALT && any_pending) |=> (mode_q == MODE_NORMAL));

    // R7: without the keypad condition stop persists
    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STOP && !key_pending) |=> (mode_q == MODE_STOP));

    // R8: a request whose wake condition already holds changes nothing
    p_refuse_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL && any_pending) |=> (mode_q != MODE_HALT));
endmodule

// File: rtl/pwr_irq_ctrl.sv
`timescale 1ns/1ps
module pwr_irq_ctrl
    import pwrirq_pkg::*;
#(
    parameter int SRC_W   = 14,
    parameter int KEY_BIT = 12,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SRC_W-1:0]  irq_src,
    output logic              irq_line,
    output logic              cpu_run,
    output logic              dma_run,
    output logic              timer_tick_enable
);
    localparam int PAD_W = DATA_W - SRC_W;

    logic [SRC_W-1:0] enable_q, flag_q, live;
    logic             master_q, any_pending, key_pending;
    pm_mode_e         mode_q;

    irq_regs #(.SRC_W(SRC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_bits   (wr_data[SRC_W-1:0]),
        .wr_bit0   (wr_data[0]),
        .src_pulse (irq_src),
        .enable_q  (enable_q),
        .flag_q    (flag_q),
        .master_q  (master_q)
    );

    always_comb begin
        live        = enable_q & flag_q;
        any_pending = |live;
        key_pending = live[KEY_BIT];
        irq_line    = master_q && any_pending;
    end

    pm_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (wr_en && (wr_addr == REG_MODE)),
        .mode_wdata  (wr_data),
        .any_pending (any_pending),
        .key_pending (key_pending),
        .mode_q      (mode_q),
        .cpu_run     (cpu_run),
        .dma_run     (dma_run),
        .timer_en    (timer_tick_enable)
    );

    always_comb begin
        unique case (rd_addr)
            REG_ENABLE: rd_data = {{PAD_W{1'b0}}, enable_q};
            REG_FLAG:   rd_data = {{PAD_W{1'b0}}, flag_q};
            REG_MASTER: rd_data = {{(DATA_W-1){1'b0}}, master_q};
            default:    rd_data = {{(DATA_W-2){1'b0}}, mode_q};
        endcase
    end

    // R2: with the master switch clear no request reaches the processor
    p_master_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q |-> !irq_line);
endmodule

// File: tb/pwr_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd3;
    logic [15:0] rd_data;
    logic [13:0] irq_src = 14'd0;
    logic        irq_line, cpu_run, dma_run, timer_tick_enable;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1";
    bit done = 1'b0;

    // reference model state
    int m_en = 0, m_flag = 0, m_mast = 0, m_mode = 0;

    always #5 clk = ~clk;

    pwr_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_src(irq_src), .irq_line(irq_line), .cpu_run(cpu_run),
        .dma_run(dma_run), .timer_tick_enable(timer_tick_enable)
    );

    always @(posedge clk) begin
        int pend, key, clr, nflag, nmode;
        if (!rst_n) begin
            m_en = 0; m_flag = 0; m_mast = 0; m_mode = 0;
        end else begin
            pend  = ((m_en & m_flag) != 0) ? 1 : 0;
            key   = (((m_en & m_flag) >> 12) & 1);
            clr   = (wr_en && wr_addr == 2'd1) ? int'(wr_data[13:0]) : 0;
            nflag = (m_flag & ~clr) | int'(irq_src);
            nmode = m_mode;
            if (m_mode == 0 && wr_en && wr_addr == 2'd3) begin
                if (wr_data == 16'd1 && pend == 0) nmode = 1;
                if (wr_data == 16'd2 && key == 0)  nmode = 2;
            end else if (m_mode == 1 && pend == 1) nmode = 0;
            else if (m_mode == 2 && key == 1) nmode = 0;
            if (wr_en && wr_addr == 2'd0) m_en = int'(wr_data[13:0]);
            if (wr_en && wr_addr == 2'd2) m_mast = int'(wr_data[0]);
            m_flag = nflag & 16'h3fff;
            m_mode = nmode;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int model_rd(logic [1:0] a);
        case (a)
            2'd0: return m_en;
            2'd1: return m_flag;
            2'd2: return m_mast;
            default: return m_mode;
        endcase
    endfunction

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "irq_line (R2)", int'(irq_line),
                  (m_mast != 0 && (m_en & m_flag) != 0) ? 1 : 0);
            check(phase, "cpu_run (R4)", int'(cpu_run), (m_mode == 0) ? 1 : 0);
            check(phase, "dma_run (R6)", int'(dma_run), (m_mode != 2) ? 1 : 0);
            check(phase, "timer_tick_enable (R6)", int'(timer_tick_enable), (m_mode != 2) ? 1 : 0);
            check(phase, "rd_data (R9)", int'(rd_data), model_rd(rd_addr));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        step();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(logic [13:0] s);
        step();
        irq_src = s;
        step();
        irq_src = 14'd0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, int exp);
        rd_addr = a; #1;
        check(tag, "readback", int'(rd_data), exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "cpu_run", int'(cpu_run), 1);
        check("R1", "dma_run", int'(dma_run), 1);
        check("R1", "timer", int'(timer_tick_enable), 1);
        check("R1", "irq_line", int'(irq_line), 0);
        rd_chk("R1", 2'd0, 0);
        rd_chk("R1", 2'd1, 0);
        rd_chk("R1", 2'd2, 0);
        rd_chk("R1", 2'd3, 0);

        // R2 masking
        phase = "R2";
        wr(2'd0, 16'h0004);
        pulse(14'h0008);
        check("R2", "irq unenabled", int'(irq_line), 0);
        pulse(14'h0004);
        check("R2", "irq master off", int'(irq_line), 0);
        wr(2'd2, 16'h0001);
        check("R2", "irq on", int'(irq_line), 1);
        rd_chk("R9", 2'd2, 1);
        rd_chk("R9", 2'd0, 16'h0004);

        // R3 write-one-to-clear, set wins
        phase = "R3";
        wr(2'd1, 16'h0004);
        rd_chk("R3", 2'd1, 16'h0008);
        check("R3", "irq after clear", int'(irq_line), 0);
        step();
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0008; irq_src = 14'h0008;
        step();
        wr_en = 1'b0; irq_src = 14'd0;
        rd_chk("R3", 2'd1, 16'h0008);
        wr(2'd1, 16'h3fff);
        rd_chk("R3", 2'd1, 0);

        // R4/R5 halt with master clear
        phase = "R5";
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0001);
        check("R4", "cpu_run in halt", int'(cpu_run), 0);
        check("R4", "dma_run in halt", int'(dma_run), 1);
        check("R4", "timer in halt", int'(timer_tick_enable), 1);
        rd_chk("R9", 2'd3, 1);
        wr(2'd3, 16'h0002);
        rd_chk("R10", 2'd3, 1);
        pulse(14'h0020);
        check("R5", "unenabled keeps halt", int'(cpu_run), 0);
        pulse(14'h0004);
        check("R5", "still halt at flag edge", int'(cpu_run), 0);
        step();
        check("R5", "woken", int'(cpu_run), 1);

        // R8 refused request: bit2 still pending and enabled
        phase = "R8";
        wr(2'd3, 16'h0001);
        rd_chk("R8", 2'd3, 0);
        step();
        check("R8", "still running", int'(cpu_run), 1);
        wr(2'd1, 16'h3fff);

        // R10 invalid codes
        phase = "R10";
        wr(2'd3, 16'h0003);
        rd_chk("R10", 2'd3, 0);
        wr(2'd3, 16'h0101);
        rd_chk("R10", 2'd3, 0);

        // R6/R7 stop
        phase = "R7";
        wr(2'd0, 16'h1004);
        wr(2'd3, 16'h0002);
        check("R6", "cpu_run in stop", int'(cpu_run), 0);
        check("R6", "dma_run in stop", int'(dma_run), 0);
        check("R6", "timer in stop", int'(timer_tick_enable), 0);
        rd_chk("R9", 2'd3, 2);
        pulse(14'h0004);
        repeat (3) step();
        check("R7", "other source ignored", int'(dma_run), 0);
        pulse(14'h1000);
        check("R7", "stop at flag edge", int'(timer_tick_enable), 0);
        step();
        check("R7", "keypad wake", int'(timer_tick_enable), 1);

        // R8 stop refused while keypad pending
        phase = "R8";
        wr(2'd3, 16'h0002);
        rd_chk("R8", 2'd3, 0);
        wr(2'd1, 16'h3fff);
        repeat (3) step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule